// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is one DMA channel that walks a linked list of transfer descriptors kept in ordinary memory. Each descriptor occupies four 32-bit words: a link to the next descriptor, a source address, a target address and a command word. When the run input is raised, the channel reads the descriptor at the head address and moves the byte count named by the command from source to target, one beat at a time. The command also selects the beat width, the burst size, address stepping, peripheral pacing and the two per-descriptor events. The channel then follows the link, or halts if the link carries the stop flag.

All traffic goes through a single memory master port. The request side is valid/ready. The channel raises `mem_req_valid` and holds address, direction, size and write data unchanged until it samples `mem_req_ready` high. It keeps at most one request outstanding. Each accepted request is answered by exactly one response cycle (`mem_rsp_valid`), which arrives no earlier than the cycle after acceptance. Responses have no back-pressure. Data on the port is right-aligned: a beat of N bytes uses the low N byte lanes. Control and status pins (`run`, `periph_req`, `busy`, `stopped` and the event pulses) are plain levels or one-cycle pulses.

Top module: `dchan_engine`

## Requirements
- R1: Out of reset the channel is idle. `busy`, `stopped`, `mem_req_valid` and all three event pulses are low.
- R2: A request stays valid with stable fields until it is accepted, and only one request is outstanding at a time. Size code 0, 1 or 2 means 1, 2 or 4 bytes.
- R3: When `run` is high in idle, the channel clears the low four bits of `chain_head`. It then reads the descriptor as four 4-byte words at offsets 0, 4, 8 and 12: link, source, target, command.
- R4: Each beat reads width bytes at the current source and writes the same right-aligned value to the current target. The width comes from command bits 15:14: 1 gives 1 byte, 2 gives 2 bytes, and 3 or 0 give 4 bytes.
- R5: Command bits 12:0 give the byte length. The channel issues ceil(length/width) beats, and a length of zero moves nothing.
- R6: After each beat, the source advances by the width when command bit 31 is set and the target does so when bit 30 is set. Otherwise that address stays fixed.
- R7: If command bit 29 or bit 28 is set, the channel waits for `periph_req` high before every burst. Burst bytes come from bits 17:16: 1 or 0 gives 8, 2 gives 16, 3 gives 32. Burst beats are burst bytes divided by the width. With neither bit set, beats run back to back.
- R8: After the last beat, a clear link bit 0 makes the channel fetch the next descriptor at the link with bits 3:0 cleared. A set bit 0 ends the chain.
- R9: `start_evt` pulses for one cycle once a descriptor whose command bit 22 is set has been fetched. `end_evt` pulses once the last write of a descriptor whose bit 21 is set has been answered.
- R10: An error response to any request pulses `buserr_evt`. The channel then issues no further requests and enters the stop state.
- R11: After the chain ends or an error occurs, `stopped` stays high and no request is made while `run` stays high. Dropping `run` returns the channel to idle, with `stopped` low, within two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Start level; sampled in idle and stop states |
| chain_head | input | AW | Address of the first descriptor |
| periph_req | input | 1 | Peripheral pacing request |
| mem_req_valid | output | 1 | Request valid |
| mem_req_ready | input | 1 | Request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Byte address |
| mem_req_size | output | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| mem_req_wdata | output | 32 | Right-aligned write data |
| mem_rsp_valid | input | 1 | Response for the outstanding request |
| mem_rsp_data | input | 32 | Right-aligned read data |
| mem_rsp_err | input | 1 | Error response |
| busy | output | 1 | Chain in progress |
| stopped | output | 1 | Chain ended or aborted; held until run drops |
| start_evt | output | 1 | Descriptor start event pulse |
| end_evt | output | 1 | Descriptor end event pulse |
| buserr_evt | output | 1 | Memory error event pulse |

## Verification
The bench stalls `mem_req_ready` in a fixed pattern and compares every write against a reference walk of the descriptors. A channel that drops the held request, shifts data into the wrong lanes, or steps a fixed peripheral address would fail on address, size or data. Length 3 at a 2-byte width checks rounding up to two beats, and length zero checks that nothing moves but the end event still fires. The pacing test holds `periph_req` low, then pulses it once: a channel that ignores the request, or that miscounts burst beats, writes too much before the next pulse. Other tests use an unaligned head address, place the source in an error region, and keep `run` high after the end, which catch fetching at the wrong offsets, writing after an error, and leaving the stop state early.

// File: rtl/dchan_pkg.sv
package dchan_pkg;

  localparam int LEN_W = 13;
  localparam int BB_W  = 6;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FISSUE, ST_FWAIT, ST_GATE, ST_RISSUE,
    ST_RWAIT, ST_WISSUE, ST_WWAIT, ST_NEXT, ST_HALT
  } dchan_state_e;

  typedef struct packed {
    logic [31:0] link;
    logic [31:0] src;
    logic [31:0] tgt;
    logic [31:0] cmd;
  } dchan_desc_t;

  function automatic logic [1:0] size_code(input logic [31:0] c);
    case (c[15:14])
      2'd1:    return 2'd0;
      2'd2:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic [2:0] width_bytes(input logic [31:0] c);
    return 3'd1 << size_code(c);
  endfunction

  function automatic logic [BB_W-1:0] burst_beats(input logic [31:0] c);
    logic [BB_W-1:0] b;
    case (c[17:16])
      2'd2:    b = 6'd16;
      2'd3:    b = 6'd32;
      default: b = 6'd8;
    endcase
    return b >> size_code(c);
  endfunction

  function automatic logic [31:0] lane_mask(input logic [31:0] c);
    case (size_code(c))
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/dchan_mem_if.sv
module dchan_mem_if #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  input  logic [DW-1:0] wdata,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          err,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [1:0]    req_size,
  output logic [DW-1:0] req_wdata,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  input  logic          rsp_err
);

  logic          pend_q, wait_q, wr_q;
  logic [AW-1:0] addr_q;
  logic [1:0]    size_q;
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      wait_q  <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      size_q  <= '0;
      wdata_q <= '0;
    end else begin
      if (start) begin
        pend_q  <= 1'b1;
        wr_q    <= wr;
        addr_q  <= addr;
        size_q  <= size;
        wdata_q <= wdata;
      end else if (pend_q && req_ready) begin
        pend_q <= 1'b0;
        wait_q <= 1'b1;
      end
      if (wait_q && rsp_valid) wait_q <= 1'b0;
    end
  end

  assign req_valid = pend_q;
  assign req_write = wr_q;
  assign req_addr  = addr_q;
  assign req_size  = size_q;
  assign req_wdata = wdata_q;
  assign done      = wait_q && rsp_valid;
  assign rdata     = rsp_data;
  assign err       = rsp_err;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_wdata))); // R2
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!pend_q && !wait_q)); // R2

endmodule

// File: rtl/dchan_addr_gen.sv
module dchan_addr_gen #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] tgt_in,
  input  logic          step,
  input  logic          inc_src,
  input  logic          inc_tgt,
  input  logic [2:0]    stride,
  output logic [AW-1:0] src,
  output logic [AW-1:0] tgt
);

  logic [AW-1:0] stride_w;
  assign stride_w = AW'(stride);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src <= '0;
      tgt <= '0;
    end else if (load) begin
      src <= src_in;
      tgt <= tgt_in;
    end else if (step) begin
      if (inc_src) src <= src + stride_w;
      if (inc_tgt) tgt <= tgt + stride_w;
    end
  end

endmodule

// File: rtl/dchan_len_ctr.sv
module dchan_len_ctr
  import dchan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  input  logic             bload,
  input  logic [BB_W-1:0]  bbeats,
  input  logic             step,
  input  logic [2:0]       wb,
  output logic             last_beat,
  output logic             burst_last
);

  logic [LEN_W-1:0] rem_q;
  logic [BB_W-1:0]  bleft_q;

  assign last_beat  = rem_q <= LEN_W'(wb);
  assign burst_last = bleft_q <= BB_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= '0;
      bleft_q <= '0;
    end else begin
      if (load) rem_q <= len;
      else if (step) rem_q <= last_beat ? '0 : rem_q - LEN_W'(wb);
      if (bload) bleft_q <= bbeats;
      else if (step && bleft_q != '0) bleft_q <= bleft_q - 1'b1;
    end
  end

  AST_REM_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && rem_q != '0) |=> (rem_q < $past(rem_q))); // R5

endmodule

// File: rtl/dchan_engine.sv
module dchan_engine
  import dchan_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [AW-1:0] chain_head,
  input  logic          periph_req,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [1:0]    mem_req_size,
  output logic [31:0]   mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data,
  input  logic          mem_rsp_err,
  output logic          busy,
  output logic          stopped,
  output logic          start_evt,
  output logic          end_evt,
  output logic          buserr_evt
);

  localparam int ALIGN = 4;

  dchan_state_e  state_q;
  dchan_desc_t   desc_q;
  logic [AW-1:0] cur_q;
  logic [1:0]    widx_q;
  logic [31:0]   data_q;

  logic          m_start, m_wr, m_done, m_err;
  logic [AW-1:0] m_addr;
  logic [1:0]    m_size;
  logic [31:0]   m_rdata;
  logic [AW-1:0] src_a, tgt_a;
  logic          ag_load, step, bload, last_beat, burst_last, flow, gate_ok;
  logic [2:0]    wb;

  assign wb      = width_bytes(desc_q.cmd);
  assign flow    = desc_q.cmd[29] | desc_q.cmd[28];
  assign gate_ok = !flow || periph_req;
  assign ag_load = state_q == ST_FWAIT && m_done && !m_err && widx_q == 2'd3;
  assign bload   = state_q == ST_GATE && gate_ok;
  assign step    = state_q == ST_WWAIT && m_done && !m_err;

  assign m_start = state_q == ST_FISSUE || state_q == ST_RISSUE || state_q == ST_WISSUE;
  assign m_wr    = state_q == ST_WISSUE;
  assign m_size  = (state_q == ST_FISSUE) ? 2'd2 : size_code(desc_q.cmd);

  always_comb begin
    case (state_q)
      ST_FISSUE: m_addr = cur_q + AW'({widx_q, 2'b00});
      ST_RISSUE: m_addr = src_a;
      default:   m_addr = tgt_a;
    endcase
  end

  dchan_mem_if #(.AW(AW), .DW(32)) u_mem (
    .clk(clk), .rst_n(rst_n), .start(m_start), .wr(m_wr), .addr(m_addr),
    .size(m_size), .wdata(data_q), .done(m_done), .rdata(m_rdata), .err(m_err),
    .req_valid(mem_req_valid), .req_ready(mem_req_ready), .req_write(mem_req_write),
    .req_addr(mem_req_addr), .req_size(mem_req_size), .req_wdata(mem_req_wdata),
    .rsp_valid(mem_rsp_valid), .rsp_data(mem_rsp_data), .rsp_err(mem_rsp_err)
  );

  dchan_addr_gen #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(ag_load), .src_in(desc_q.src[AW-1:0]),
    .tgt_in(desc_q.tgt[AW-1:0]), .step(step), .inc_src(desc_q.cmd[31]),
    .inc_tgt(desc_q.cmd[30]), .stride(wb), .src(src_a), .tgt(tgt_a)
  );

  dchan_len_ctr u_len (
    .clk(clk), .rst_n(rst_n), .load(ag_load), .len(m_rdata[LEN_W-1:0]),
    .bload(bload), .bbeats(burst_beats(desc_q.cmd)), .step(step), .wb(wb),
    .last_beat(last_beat), .burst_last(burst_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      desc_q     <= '0;
      cur_q      <= '0;
      widx_q     <= '0;
      data_q     <= '0;
      start_evt  <= 1'b0;
      end_evt    <= 1'b0;
      buserr_evt <= 1'b0;
    end else begin
      start_evt  <= 1'b0;
      end_evt    <= 1'b0;
      buserr_evt <= 1'b0;
      case (state_q)
        ST_IDLE: if (run) begin
          cur_q   <= {chain_head[AW-1:ALIGN], {ALIGN{1'b0}}};
          widx_q  <= 2'd0;
          state_q <= ST_FISSUE;
        end
        ST_FISSUE: state_q <= ST_FWAIT;
        ST_FWAIT: if (m_done) begin
          if (m_err) begin
            buserr_evt <= 1'b1;
            state_q    <= ST_HALT;
          end else begin
            case (widx_q)
              2'd0:    desc_q.link <= m_rdata;
              2'd1:    desc_q.src  <= m_rdata;
              2'd2:    desc_q.tgt  <= m_rdata;
              default: desc_q.cmd  <= m_rdata;
            endcase
            if (widx_q == 2'd3) begin
              start_evt <= m_rdata[22];
              state_q   <= (m_rdata[LEN_W-1:0] == '0) ? ST_NEXT : ST_GATE;
            end else begin
              widx_q  <= widx_q + 2'd1;
              state_q <= ST_FISSUE;
            end
          end
        end
        ST_GATE: if (gate_ok) state_q <= ST_RISSUE;
        ST_RISSUE: state_q <= ST_RWAIT;
        ST_RWAIT: if (m_done) begin
          if (m_err) begin
            buserr_evt <= 1'b1;
            state_q    <= ST_HALT;
          end else begin
            data_q  <= m_rdata & lane_mask(desc_q.cmd);
            state_q <= ST_WISSUE;
          end
        end
        ST_WISSUE: state_q <= ST_WWAIT;
        ST_WWAIT: if (m_done) begin
          if (m_err) begin
            buserr_evt <= 1'b1;
            state_q    <= ST_HALT;
          end else if (last_beat) state_q <= ST_NEXT;
          else if (burst_last)    state_q <= ST_GATE;
          else                    state_q <= ST_RISSUE;
        end
        ST_NEXT: begin
          end_evt <= desc_q.cmd[21];
          if (desc_q.link[0]) state_q <= ST_HALT;
          else begin
            cur_q   <= {desc_q.link[AW-1:ALIGN], {ALIGN{1'b0}}};
            widx_q  <= 2'd0;
            state_q <= ST_FISSUE;
          end
        end
        ST_HALT: if (!run) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy    = state_q != ST_IDLE && state_q != ST_HALT;
  assign stopped = state_q == ST_HALT;

  AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GATE && flow && !periph_req) |=> (state_q == ST_GATE)); // R7
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT) |-> !mem_req_valid); // R10
  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_evt, end_evt, buserr_evt})); // R9
  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    buserr_evt |-> stopped); // R10

endmodule

// File: tb/tb_dchan_engine.sv
module tb_dchan_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [31:0] chain_head = '0;
  logic        periph_req = 1'b0;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic [1:0]  mem_req_size;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        mem_rsp_err = 1'b0;
  logic        busy, stopped, start_evt, end_evt, buserr_evt;

  always #10 clk = ~clk;

  dchan_engine dut (.*);

  int nchk = 0, nerr = 0;
  int obs_req = 0, obs_wr = 0, obs_start = 0, obs_end = 0, obs_err = 0;
  int exp_start = 0, exp_end = 0, exp_err = 0;
  logic [7:0]  mem_b [0:4095];
  logic [65:0] expq [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [65:0] act, input logic [65:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_n(input logic [31:0] a, input int n);
    logic [31:0] v = '0;
    for (int i = 0; i < n; i++) v[8*i +: 8] = mem_b[(a + i) & 32'hFFF];
    return v;
  endfunction

  task automatic wr32(input logic [31:0] a, input logic [31:0] v);
    for (int i = 0; i < 4; i++) mem_b[a + i] = v[8*i +: 8];
  endtask

  task automatic put_desc(input logic [31:0] at, input logic [31:0] link,
                          input logic [31:0] s, input logic [31:0] t, input logic [31:0] c);
    wr32(at, link); wr32(at + 4, s); wr32(at + 8, t); wr32(at + 12, c);
  endtask

  // reference walk of the chain, pushes expected writes
  task automatic build_expect(input logic [31:0] head);
    logic [31:0] a, link, s, t, c;
    int wbytes, beats, len;
    a = head & ~32'hF;
    exp_start = 0; exp_end = 0; exp_err = 0;
    forever begin
      link = rd_n(a, 4); s = rd_n(a + 4, 4); t = rd_n(a + 8, 4); c = rd_n(a + 12, 4);
      if (c[22]) exp_start++;
      wbytes = (c[15:14] == 2'd1) ? 1 : (c[15:14] == 2'd2) ? 2 : 4;
      len = int'(c[12:0]);
      beats = (len + wbytes - 1) / wbytes;
      for (int b = 0; b < beats; b++) begin
        if (s >= 32'h1000) begin exp_err++; return; end
        expq.push_back({t, 2'(wbytes == 1 ? 0 : wbytes == 2 ? 1 : 2), rd_n(s, wbytes)});
        if (c[31]) s += wbytes;
        if (c[30]) t += wbytes;
      end
      if (c[21]) exp_end++;
      if (link[0]) return;
      a = link & ~32'hF;
    end
  endtask

  // memory responder and scoreboard monitor
  initial begin
    int cyc = 0;
    bit pend = 0;
    logic [31:0] pdata = '0;
    logic perr = 0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = 1'b0;
      if (pend) begin
        mem_rsp_valid = 1'b1; mem_rsp_data = pdata; mem_rsp_err = perr; pend = 0;
      end
      mem_req_ready = (cyc % 3) != 1;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        obs_req++;
        perr = mem_req_addr >= 32'h1000;
        pdata = '0;
        if (mem_req_write) begin
          logic [65:0] e, act;
          obs_wr++;
          act = {mem_req_addr, mem_req_size, mem_req_wdata};
          if (expq.size() == 0) chk(1'b0, "R4", "unexpected write", act, '0);
          else begin
            e = expq.pop_front();
            chk(act == e, "R4", "write addr/size/data (R2 size, R6 step)", act, e);
          end
          if (!perr)
            for (int i = 0; i < (1 << mem_req_size); i++)
              mem_b[(mem_req_addr + i) & 32'hFFF] = mem_req_wdata[8*i +: 8];
        end else if (!perr) pdata = rd_n(mem_req_addr, 1 << mem_req_size);
        pend = 1;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (start_evt) obs_start++;
    if (end_evt) obs_end++;
    if (buserr_evt) obs_err++;
  end

  task automatic start_chain(input logic [31:0] head);
    expq.delete();
    build_expect(head);
    obs_wr = 0; obs_start = 0; obs_end = 0; obs_err = 0;
    @(negedge clk);
    chain_head = head;
    run = 1'b1;
  endtask

  task automatic finish_chain(input string name);
    int r0;
    for (int i = 0; i < 4000 && !stopped; i++) @(negedge clk);
    chk(stopped, "R8", {name, " chain stopped"}, stopped, 1);
    chk(expq.size() == 0, "R8", {name, " all writes done"}, expq.size(), 0);
    chk(obs_start == exp_start, "R9", {name, " start events"}, obs_start, exp_start);
    chk(obs_end == exp_end, "R9", {name, " end events"}, obs_end, exp_end);
    chk(obs_err == exp_err, "R10", {name, " bus error events"}, obs_err, exp_err);
    r0 = obs_req;
    repeat (10) @(negedge clk);
    chk(stopped && !busy, "R11", {name, " stop state held"}, stopped, 1);
    chk(obs_req == r0, "R11", {name, " no requests while stopped"}, obs_req, r0);
    run = 1'b0;
    repeat (2) @(negedge clk);
    chk(!stopped && !busy, "R11", {name, " idle after run drops"}, stopped, 0);
  endtask

  localparam logic [31:0] INC2 = 32'hC000_0000;

  initial begin
    for (int i = 0; i < 4096; i++) mem_b[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    chk(!busy && !stopped && !mem_req_valid && !start_evt && !end_evt && !buserr_evt,
        "R1", "reset state", {busy, stopped, mem_req_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 unaligned head, R4 widths 4 and 2, R8 two-link chain, R9 events
    put_desc(32'h100, 32'h200, 32'h400, 32'h800, INC2 | 32'h0040_0000 | (3 << 16) | (3 << 14) | 16);
    put_desc(32'h200, 32'h1, 32'h440, 32'h840, INC2 | 32'h0020_0000 | (2 << 16) | (2 << 14) | 6);
    start_chain(32'h105);
    finish_chain("T1");
    chk(rd_n(32'h840, 4) == rd_n(32'h440, 4), "R3", "T1 target data", rd_n(32'h840, 4), rd_n(32'h440, 4));

    // R7 target pacing, R6 fixed target, width 1
    put_desc(32'h300, 32'h1, 32'h500, 32'hC00, 32'h8000_0000 | 32'h1000_0000 | 32'h0020_0000 | (1 << 16) | (1 << 14) | 5);
    periph_req = 1'b0;
    start_chain(32'h300);
    repeat (40) @(negedge clk);
    chk(obs_wr == 0, "R7", "T2 no writes without request", obs_wr, 0);
    periph_req = 1'b1;
    finish_chain("T2");
    chk(mem_b[12'hC00] == mem_b[12'h504], "R6", "T2 fixed target last byte", mem_b[12'hC00], mem_b[12'h504]);
    chk(obs_wr == 5, "R5", "T2 beat count", obs_wr, 5);

    // R5 rounding: length 3 at width 2
    put_desc(32'h340, 32'h1, 32'h480, 32'h880, INC2 | 32'h0020_0000 | (2 << 14) | 3);
    start_chain(32'h340);
    finish_chain("T3");
    chk(obs_wr == 2, "R5", "T3 rounded beats", obs_wr, 2);

    // R5 zero length still gives end event
    put_desc(32'h380, 32'h1, 32'h4C0, 32'h8C0, INC2 | 32'h0020_0000 | (3 << 14));
    start_chain(32'h380);
    finish_chain("T4");
    chk(obs_wr == 0, "R5", "T4 zero length moves nothing", obs_wr, 0);

    // R7 burst gating: width 4, burst 8 -> 2 beats per request
    put_desc(32'h3C0, 32'h1, 32'hC40, 32'h900, 32'h4000_0000 | 32'h2000_0000 | (1 << 16) | (3 << 14) | 16);
    periph_req = 1'b0;
    start_chain(32'h3C0);
    repeat (40) @(negedge clk);
    chk(obs_wr == 0, "R7", "T5 gated before request", obs_wr, 0);
    periph_req = 1'b1;
    @(negedge clk);
    periph_req = 1'b0;
    repeat (40) @(negedge clk);
    chk(obs_wr == 2, "R7", "T5 one burst per request", obs_wr, 2);
    periph_req = 1'b1;
    finish_chain("T5");

    // R10 error on source read
    put_desc(32'h600, 32'h1, 32'h9000, 32'h980, INC2 | 32'h0020_0000 | (3 << 14) | 8);
    start_chain(32'h600);
    finish_chain("T6");
    chk(obs_wr == 0, "R10", "T6 no write after error", obs_wr, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule